// File: doc/BRIEF.md
# Three-Phase Dead-Time Insertion Generator

This block turns three PWM source signals, one per motor phase, into three complementary gate-drive pairs. Each pair has an upper output that follows its source and a lower output that follows the inverse of that source. Whenever the source of a phase changes level, both outputs of that pair are first driven inactive. The output that is about to switch on stays off until a per-phase 16-bit down-counter has run out. The counter is loaded from a per-phase delay value and decrements once per pulse of a shared count-enable input, which normally comes from a prescaler.

A single counter per phase serves both the rising and the falling transition. If the source changes again while the counter is still running, the counter reloads and starts again from the full value. A pulse narrower than the dead time therefore never reaches the outputs as a glitch; it only stretches the inactive gap. A per-phase polarity bit sets whether the outputs are active-low or active-high. A per-phase 3-bit mode field turns the function on for that phase only when it equals binary 100.

Top module: `deadtime_gen`

## Requirements
- R1: While reset is asserted, all six outputs sit at their inactive level: high for a phase whose polarity bit is 0, low for a phase whose polarity bit is 1.
- R2: A polarity bit of 0 makes that phase's outputs active-low; a polarity bit of 1 makes them active-high.
- R3: A phase whose 3-bit mode field is not 3'b100 holds both of its outputs inactive and clears its counter. When the field returns to 3'b100, that phase restarts from the level of its source.
- R4: One clock after a rising source edge is sampled, both outputs of the pair are inactive. The upper output asserts only while the source was sampled high.
- R5: After a falling source edge, the lower output asserts once the delay expires. It asserts only while the source was sampled low.
- R6: The upper and lower outputs of a pair are never active in the same cycle.
- R7: With the count enable held high, the inactive gap after each source edge lasts exactly as many clock cycles as the phase's delay value.
- R8: A delay value of 0 inserts no gap: the pair swaps outputs directly, one clock after the sampled edge.
- R9: A source edge that arrives while the counter is running reloads the full delay. A pulse of width P with delay D gives a gap of P+D cycles, and the short pulse never activates its output.
- R10: The counter decrements only on cycles with the count enable high. With one enable every four clocks, a delay of D gives a gap of 4*D clocks when the edge falls on an enable cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_tick | input | 1 | Count enable from prescaler; counters step on cycles it is high |
| src | input | NPH | PWM source per phase (bit 0 = U, 1 = V, 2 = W) |
| mode | input | NPH*3 | Per-phase mode field, 3 bits per phase; 3'b100 enables |
| pol | input | NPH | Per-phase polarity: 0 active-low, 1 active-high |
| gap | input | NPH*CW | Per-phase delay value, CW bits per phase |
| hi_out | output | NPH | Upper outputs U, V, W |
| lo_out | output | NPH | Lower outputs X, Y, Z |

## Verification
A corrupted counter shows up at the ports at the next source transition. The measured inactive gap is then longer or shorter than the programmed count, and the scoreboard reports this as soon as the pair reactivates. A stale registered copy of the source shows within one clock: an output asserts that disagrees with the level the source had on the previous edge, or both outputs of a pair assert together. A missed reload on a narrow pulse shows as a gap equal to the plain delay instead of the pulse width plus the delay.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
    localparam int MODE_W = 3;
    localparam logic [MODE_W-1:0] MODE_DEADTIME = 3'b100;

    typedef enum logic {
        POL_ACT_LOW  = 1'b0,
        POL_ACT_HIGH = 1'b1
    } pol_e;
endpackage

// File: rtl/dtg_mode_decode.sv
module dtg_mode_decode
    import dtg_pkg::*;
#(
    parameter int NPH = 3
) (
    input  logic [NPH*MODE_W-1:0] mode,
    output logic [NPH-1:0]        en
);
    for (genvar i = 0; i < NPH; i++) begin : g_dec
        assign en[i] = (mode[i*MODE_W +: MODE_W] == MODE_DEADTIME);
    end
endmodule

// File: rtl/dtg_phase.sv
module dtg_phase #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  logic          src,
    input  logic [CW-1:0] gap,
    output logic          up_act,
    output logic          lo_act
);
    typedef struct packed {
        logic          src;
        logic [CW-1:0] cnt;
        logic          up;
        logic          lo;
    } phase_st_t;

    phase_st_t st_d, st_q;
    logic      edge_d;
    logic      gap_zero_d;

    always_comb begin
        st_d       = st_q;
        edge_d     = src ^ st_q.src;
        gap_zero_d = (gap == '0);
        if (!en) begin
            st_d.src = 1'b0;
            st_d.cnt = '0;
            st_d.up  = 1'b0;
            st_d.lo  = 1'b0;
        end else begin
            st_d.src = src;
            if (edge_d) begin
                st_d.cnt = gap;
                st_d.up  = gap_zero_d & src;
                st_d.lo  = gap_zero_d & ~src;
            end else if (st_q.cnt != '0) begin
                st_d.up = 1'b0;
                st_d.lo = 1'b0;
                if (tick) begin
                    st_d.cnt = st_q.cnt - CW'(1);
                    if (st_q.cnt == CW'(1)) begin
                        st_d.up = st_q.src;
                        st_d.lo = ~st_q.src;
                    end
                end
            end else begin
                st_d.up = st_q.src;
                st_d.lo = ~st_q.src;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign up_act = st_q.up;
    assign lo_act = st_q.lo;
endmodule

// File: rtl/dtg_out_drive.sv
module dtg_out_drive
    import dtg_pkg::*;
(
    input  logic pol,
    input  logic up_act,
    input  logic lo_act,
    output logic hi_o,
    output logic lo_o
);
    always_comb begin
        if (pol_e'(pol) == POL_ACT_HIGH) begin
            hi_o = up_act;
            lo_o = lo_act;
        end else begin
            hi_o = ~up_act;
            lo_o = ~lo_act;
        end
    end
endmodule

// File: rtl/deadtime_gen.sv
module deadtime_gen
    import dtg_pkg::*;
#(
    parameter int NPH = 3,
    parameter int CW  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cnt_tick,
    input  logic [NPH-1:0]        src,
    input  logic [NPH*MODE_W-1:0] mode,
    input  logic [NPH-1:0]        pol,
    input  logic [NPH*CW-1:0]     gap,
    output logic [NPH-1:0]        hi_out,
    output logic [NPH-1:0]        lo_out
);
    logic [NPH-1:0] en;
    logic [NPH-1:0] up_act;
    logic [NPH-1:0] lo_act;

    dtg_mode_decode #(.NPH(NPH)) u_dec (
        .mode (mode),
        .en   (en)
    );

    for (genvar i = 0; i < NPH; i++) begin : g_ph
        dtg_phase #(.CW(CW)) u_phase (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (en[i]),
            .tick   (cnt_tick),
            .src    (src[i]),
            .gap    (gap[i*CW +: CW]),
            .up_act (up_act[i]),
            .lo_act (lo_act[i])
        );

        dtg_out_drive u_drv (
            .pol    (pol[i]),
            .up_act (up_act[i]),
            .lo_act (lo_act[i]),
            .hi_o   (hi_out[i]),
            .lo_o   (lo_out[i])
        );
    end
endmodule

// File: rtl/dtg_chk.sv
module dtg_chk
    import dtg_pkg::*;
#(
    parameter int NPH = 3,
    parameter int CW  = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NPH-1:0]        src,
    input logic [NPH*MODE_W-1:0] mode,
    input logic [NPH-1:0]        pol,
    input logic [NPH*CW-1:0]     gap,
    input logic [NPH-1:0]        hi_out,
    input logic [NPH-1:0]        lo_out
);
    for (genvar i = 0; i < NPH; i++) begin : g_chk
        logic up_on, lo_on, en_i, gap_nz;
        assign up_on  = pol[i] ? hi_out[i] : ~hi_out[i];
        assign lo_on  = pol[i] ? lo_out[i] : ~lo_out[i];
        assign en_i   = (mode[i*MODE_W +: MODE_W] == MODE_DEADTIME);
        assign gap_nz = (gap[i*CW +: CW] != '0);

        // R6
        no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(up_on && lo_on));

        // R3
        mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(en_i) |-> (!up_on && !lo_on));

        // R4 R7
        edge_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && en_i && $past(en_i) && gap_nz && (src[i] != $past(src[i])))
            |=> (!up_on && !lo_on));

        // R4
        up_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            up_on |-> $past(src[i]));

        // R5
        lo_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            lo_on |-> !$past(src[i]));
    end
endmodule

bind deadtime_gen dtg_chk #(.NPH(NPH), .CW(CW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .src    (src),
    .mode   (mode),
    .pol    (pol),
    .gap    (gap),
    .hi_out (hi_out),
    .lo_out (lo_out)
);

// File: tb/deadtime_gen_bench.sv
module deadtime_gen_bench;
    localparam int CLK_PER = 10;
    localparam int NPH = 3;
    localparam int CW  = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cnt_tick;
    logic [NPH-1:0]    src;
    logic [NPH*3-1:0]  mode;
    logic [NPH-1:0]    pol;
    logic [NPH*CW-1:0] gap;
    logic [NPH-1:0]    hi_out, lo_out;

    logic        slow = 1'b0;
    logic [31:0] cyc = '0;
    logic        mon_on = 1'b0, mon_was = 1'b0, done = 1'b0;
    int          checks = 0, errors = 0, overlaps = 0;

    typedef struct {
        int ph;
        bit upper;
        int dead;
    } item_t;
    item_t exp_q[$];

    int dead_cnt[NPH];
    bit prev_up[NPH], prev_lo[NPH];

    always #(CLK_PER/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign cnt_tick = slow ? (cyc[1:0] == 2'd0) : 1'b1;

    deadtime_gen #(.NPH(NPH), .CW(CW)) u_deadtime_gen (
        .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .src(src), .mode(mode),
        .pol(pol), .gap(gap), .hi_out(hi_out), .lo_out(lo_out)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: measures each inactive gap and the output that ends it
    always @(negedge clk) begin
        if (mon_on && !mon_was) begin
            for (int p = 0; p < NPH; p++) begin
                prev_up[p]  = pol[p] ? hi_out[p] : ~hi_out[p];
                prev_lo[p]  = pol[p] ? lo_out[p] : ~lo_out[p];
                dead_cnt[p] = 0;
            end
        end else if (mon_on) begin
            for (int p = 0; p < NPH; p++) begin
                bit u, l;
                u = pol[p] ? hi_out[p] : ~hi_out[p];
                l = pol[p] ? lo_out[p] : ~lo_out[p];
                if (u && l) overlaps++;
                if (!u && !l) begin
                    dead_cnt[p]++;
                end else if ((u && !prev_up[p]) || (l && !prev_lo[p])) begin
                    checks++;
                    if (exp_q.size() == 0) begin
                        errors++;
                        $display("FAIL R7: unexpected event ph=%0d upper=%0d dead=%0d expected none",
                                 p, u, dead_cnt[p]);
                    end else begin
                        item_t e;
                        e = exp_q.pop_front();
                        if (e.ph != p || e.upper != u || e.dead != dead_cnt[p]) begin
                            errors++;
                            $display("FAIL R7/R8/R9/R10: actual ph=%0d upper=%0d dead=%0d expected ph=%0d upper=%0d dead=%0d",
                                     p, u, dead_cnt[p], e.ph, e.upper, e.dead);
                        end
                    end
                    dead_cnt[p] = 0;
                end
                prev_up[p] = u;
                prev_lo[p] = l;
            end
        end
        mon_was <= mon_on;
    end

    task automatic edge_to(int p, bit v, int dead);
        @(negedge clk);
        src[p] = v;
        exp_q.push_back('{p, v, dead});
    endtask

    task automatic sync_tick();
        @(negedge clk);
        while (cyc[1:0] != 2'd0) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b1; mode = '0; pol = 3'b010; src = '0; gap = '0;
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: inactive level is the inverse of the polarity bit
        chk("R1 hi_out in reset", {29'd0, hi_out}, {29'd0, ~pol});
        chk("R1 lo_out in reset", {29'd0, lo_out}, {29'd0, ~pol});
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R3: mode 000 keeps all outputs inactive
        chk("R3 hi_out mode off", {29'd0, hi_out}, {29'd0, ~pol});
        chk("R3 lo_out mode off", {29'd0, lo_out}, {29'd0, ~pol});

        gap  = {16'd0, 16'd3, 16'd5};
        mode = {3'b100, 3'b100, 3'b100};
        repeat (4) @(negedge clk);
        // R2: lower outputs active at the polarity's active level
        chk("R2 lo_out active", {29'd0, lo_out}, {29'd0, pol});
        chk("R2 hi_out inactive", {29'd0, hi_out}, {29'd0, ~pol});

        mon_on = 1'b1;
        repeat (2) @(negedge clk);
        // R4 R5 R7: gap equals delay value, active-low phase
        edge_to(0, 1'b1, 5); repeat (12) @(negedge clk);
        edge_to(0, 1'b0, 5); repeat (12) @(negedge clk);
        // R2 R7: active-high phase
        edge_to(1, 1'b1, 3); repeat (10) @(negedge clk);
        edge_to(1, 1'b0, 3); repeat (10) @(negedge clk);
        // R8: zero delay
        edge_to(2, 1'b1, 0); repeat (6) @(negedge clk);
        edge_to(2, 1'b0, 0); repeat (6) @(negedge clk);

        // R9: 3-cycle pulse with delay 6 -> gap 9, upper never active
        gap[15:0] = 16'd6;
        @(negedge clk);
        src[0] = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 upper held off during short pulse", {31'd0, hi_out[0]}, 32'd1);
        @(negedge clk);
        src[0] = 1'b0;
        exp_q.push_back('{0, 1'b0, 9});
        repeat (16) @(negedge clk);

        // R10: one enable every 4 clocks, delay 2 -> gap 8
        slow = 1'b1;
        gap[47:32] = 16'd2;
        sync_tick(); src[2] = 1'b1; exp_q.push_back('{2, 1'b1, 8});
        repeat (20) @(negedge clk);
        sync_tick(); src[2] = 1'b0; exp_q.push_back('{2, 1'b0, 8});
        repeat (20) @(negedge clk);
        slow = 1'b0;

        // R3: non-100 mode forces phase 1 inactive while its source toggles
        mon_on = 1'b0;
        @(negedge clk);
        mode[5:3] = 3'b101;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); src[1] = ~src[1];
            @(negedge clk);
            chk("R3 phase1 upper inactive", {31'd0, hi_out[1]}, 32'd0);
            chk("R3 phase1 lower inactive", {31'd0, lo_out[1]}, 32'd0);
        end
        src[1] = 1'b0;
        mode[5:3] = 3'b100;
        repeat (5) @(negedge clk);
        chk("R3 phase1 lower resumes", {31'd0, lo_out[1]}, 32'd1);

        repeat (3) @(negedge clk);
        chk("R6 overlap cycles", overlaps, 0);
        chk("R7 pending expected gaps", exp_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule